// File: doc/BRIEF.md
# Conversion Result Bank with Valid and Overrun Tracking

This block holds the conversion results of an analog-to-digital converter for a set of sample slots. Whenever the converter signals that a conversion has finished, it gives a slot index and the raw 12-bit code. The bank formats the code as straight binary or as two's complement, stores the 16-bit result in that slot, and marks the slot valid. If a slot still holds unread data when a new result comes in, the slot is flagged as overrun. A read that addresses a slot returns its data word and clears both flags.

The first few slots can each enable a second result register. In that mode, successive results go first to the primary register, then to the secondary, and keep alternating. The bank also produces two chip-wide summary bits, one for any valid data and one for any overrun. A mask chooses which slots send a one-cycle transfer request to a DMA engine when a result is loaded. The converter and the DMA engine are outside this block.

Top module: `adc_result_bank`

## Requirements
- R1: The read data word carries the result in bits 15:0, the overrun flag in bit 16 and the valid flag in bit 17. After reset every register, flag, summary and request is zero.
- R2: With `fmt_twos`=0 the stored result is the raw 12-bit code with four zero bits added above it.
- R3: With `fmt_twos`=1 the stored result is the raw code with its bit 11 inverted, then sign-extended from that inverted bit to 16 bits.
- R4: A cycle with `done_i`=1 stores the result in the slot given by `done_slot` (0 to 18) and sets that slot's valid flag. A `done_slot` value of 19 or more changes no state.
- R5: A write into a register whose valid flag is 1 sets that register's overrun flag. The overrun flag stays at 1 across further writes until a read.
- R6: A cycle with `rd_en`=1 clears the valid and overrun flags of the addressed register and keeps its result. If a read and a write hit the same register in one cycle, the register ends with valid=1, overrun=0 and the new result.
- R7: `valid_sum` is 1 exactly when any valid flag in the bank is 1. `ovr_sum` is 1 exactly when any overrun flag is 1. Both include the secondary registers.
- R8: `dma_req[i]` is a one-cycle pulse in the cycle after slot i is loaded, and only if `dma_en[i]`=1.
- R9: For slots 0 to 3 with `dbl_en[i]`=1, writes alternate between the primary and the secondary register, starting with the primary. `rd_sec`=1 selects the secondary. With `dbl_en[i]`=0 every write goes to the primary and the alternation restarts from the primary. The secondary of slots 4 to 18 reads as zero, and so does any `rd_slot` of 19 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_twos | input | 1 | Result format: 0 straight binary, 1 two's complement |
| dbl_en | input | 4 | Per-slot double-buffer enable for slots 0 to 3 |
| dma_en | input | 19 | Per-slot DMA request enable |
| done_i | input | 1 | Conversion-done strobe |
| done_slot | input | 5 | Slot index of the finished conversion |
| raw_i | input | 12 | Raw converter code |
| rd_en | input | 1 | Read strobe; clears the flags of the addressed register |
| rd_slot | input | 5 | Slot index to read |
| rd_sec | input | 1 | Selects the secondary register of the slot |
| rd_data | output | 18 | Data word of the addressed register: {valid, overrun, result} |
| valid_sum | output | 1 | OR of all valid flags |
| ovr_sum | output | 1 | OR of all overrun flags |
| dma_req | output | 19 | Per-slot one-cycle transfer request |

## Verification
The bench builds the bank with its default parameters: 19 slots, a 12-bit raw code, a 16-bit result and four slots that can use double buffering. These values let it reach both ends of the slot range (0 and 18), the first index past the range (19 and above), the edges of both formats at codes 0x000, 0x7FF, 0x800 and 0xFFF, and the alternation of a double-buffered slot, including its wrap back to the primary register. A table of format vectors is walked first. Directed cases then cover overrun, read-clear, a read and a write in the same cycle, the summary bits and the DMA pulse.

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;
   // Result formatting choice driven on fmt_twos
   typedef enum logic {
      FMT_STRAIGHT = 1'b0,
      FMT_TWOS     = 1'b1
   } res_fmt_e;

   // Flag bits sitting above the result in a data word
   localparam int FLAG_W = 2;
endpackage

// File: rtl/adc_rb_format.sv
module adc_rb_format #(
   parameter int RAW_W = 12,
   parameter int RES_W = 16
) (
   input  logic [RAW_W-1:0] raw,
   input  logic             twos,
   output logic [RES_W-1:0] res
);
   import adc_rb_pkg::*;

   localparam int EXT_W = RES_W - RAW_W;

   if (RAW_W < 2) begin : g_bad_raw
      $error("adc_rb_format: RAW_W must be at least 2");
   end
   if (EXT_W < 0) begin : g_bad_res
      $error("adc_rb_format: RES_W must not be below RAW_W");
   end

   logic top_bit;
   assign top_bit = raw[RAW_W-1] ^ (res_fmt_e'(twos) == FMT_TWOS);

   if (EXT_W == 0) begin : g_noext
      assign res = {top_bit, raw[RAW_W-2:0]};
   end else begin : g_ext
      assign res = {{EXT_W{twos & top_bit}}, top_bit, raw[RAW_W-2:0]};
   end
endmodule

// File: rtl/adc_rb_slot.sv
module adc_rb_slot #(
   parameter int RES_W   = 16,
   parameter bit HAS_DBL = 1'b0,
   localparam int WORD_W = RES_W + adc_rb_pkg::FLAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [RES_W-1:0]  wdata,
   input  logic              dbl_on,
   input  logic              rd_pri,
   input  logic              rd_scd,
   output logic [WORD_W-1:0] pri_word,
   output logic [WORD_W-1:0] sec_word
);
   logic [RES_W-1:0] p_res;
   logic             p_val, p_ovr;
   logic             wr_p;

   if (HAS_DBL) begin : g_dbl
      logic             ptr;
      logic [RES_W-1:0] s_res;
      logic             s_val, s_ovr;
      logic             wr_s;

      assign wr_p = wr & ~(dbl_on & ptr);
      assign wr_s = wr & dbl_on & ptr;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ptr <= 1'b0;
         end else if (!dbl_on) begin
            ptr <= 1'b0;
         end else if (wr) begin
            ptr <= ~ptr;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_res <= '0;
            s_val <= 1'b0;
            s_ovr <= 1'b0;
         end else if (wr_s) begin
            s_res <= wdata;
            s_val <= 1'b1;
            s_ovr <= rd_scd ? 1'b0 : (s_ovr | s_val);
         end else if (rd_scd) begin
            s_val <= 1'b0;
            s_ovr <= 1'b0;
         end
      end

      assign sec_word = {s_val, s_ovr, s_res};

      // R9
      ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (dbl_on && wr) |=> (ptr != $past(ptr)));

      // R5
      sec_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         s_ovr |-> s_val);
   end else begin : g_single
      assign wr_p     = wr;
      assign sec_word = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_res <= '0;
         p_val <= 1'b0;
         p_ovr <= 1'b0;
      end else if (wr_p) begin
         p_res <= wdata;
         p_val <= 1'b1;
         p_ovr <= rd_pri ? 1'b0 : (p_ovr | p_val);
      end else if (rd_pri) begin
         p_val <= 1'b0;
         p_ovr <= 1'b0;
      end
   end

   assign pri_word = {p_val, p_ovr, p_res};

   // R5
   pri_ovr_needs_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      p_ovr |-> p_val);

   // R5
   pri_ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_p && p_val && !rd_pri) |=> p_ovr);

   // R6
   pri_rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pri && !wr_p) |=> (!p_val && !p_ovr && $stable(p_res)));
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
   parameter int NUM_SLOTS = 19,
   parameter int DBL_SLOTS = 4,
   parameter int RAW_W     = 12,
   parameter int RES_W     = 16,
   localparam int SLOT_W   = $clog2(NUM_SLOTS),
   localparam int WORD_W   = RES_W + adc_rb_pkg::FLAG_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fmt_twos,
   input  logic [DBL_SLOTS-1:0] dbl_en,
   input  logic [NUM_SLOTS-1:0] dma_en,
   input  logic                 done_i,
   input  logic [SLOT_W-1:0]    done_slot,
   input  logic [RAW_W-1:0]     raw_i,
   input  logic                 rd_en,
   input  logic [SLOT_W-1:0]    rd_slot,
   input  logic                 rd_sec,
   output logic [WORD_W-1:0]    rd_data,
   output logic                 valid_sum,
   output logic                 ovr_sum,
   output logic [NUM_SLOTS-1:0] dma_req
);
   if (NUM_SLOTS < 2) begin : g_bad_slots
      $error("adc_result_bank: NUM_SLOTS must be at least 2");
   end
   if (DBL_SLOTS < 1 || DBL_SLOTS > NUM_SLOTS) begin : g_bad_dbl
      $error("adc_result_bank: DBL_SLOTS must lie in 1..NUM_SLOTS");
   end

   logic [RES_W-1:0]     fmt_res;
   logic [NUM_SLOTS-1:0] wr_vec, rdp_vec, rds_vec;
   logic [NUM_SLOTS-1:0] val_vec, ovr_vec;
   logic [WORD_W-1:0]    pri_w [NUM_SLOTS];
   logic [WORD_W-1:0]    sec_w [NUM_SLOTS];

   adc_rb_format #(.RAW_W(RAW_W), .RES_W(RES_W)) fmt_i (
      .raw  (raw_i),
      .twos (fmt_twos),
      .res  (fmt_res)
   );

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      logic dbl_on_i;
      assign wr_vec[i]  = done_i && (done_slot == SLOT_W'(i));
      assign rdp_vec[i] = rd_en && !rd_sec && (rd_slot == SLOT_W'(i));
      assign rds_vec[i] = rd_en &&  rd_sec && (rd_slot == SLOT_W'(i));

      if (i < DBL_SLOTS) begin : g_dbl_cap
         assign dbl_on_i = dbl_en[i];
      end else begin : g_no_dbl
         assign dbl_on_i = 1'b0;
      end

      adc_rb_slot #(.RES_W(RES_W), .HAS_DBL(i < DBL_SLOTS)) slot_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr       (wr_vec[i]),
         .wdata    (fmt_res),
         .dbl_on   (dbl_on_i),
         .rd_pri   (rdp_vec[i]),
         .rd_scd   (rds_vec[i]),
         .pri_word (pri_w[i]),
         .sec_word (sec_w[i])
      );

      assign val_vec[i] = pri_w[i][WORD_W-1] | sec_w[i][WORD_W-1];
      assign ovr_vec[i] = pri_w[i][WORD_W-2] | sec_w[i][WORD_W-2];
   end

   assign valid_sum = |val_vec;
   assign ovr_sum   = |ovr_vec;

   always_comb begin
      rd_data = '0;
      if (int'(rd_slot) < NUM_SLOTS) begin
         rd_data = rd_sec ? sec_w[rd_slot] : pri_w[rd_slot];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dma_req <= '0;
      end else begin
         dma_req <= wr_vec & dma_en;
      end
   end

   // R8
   dma_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dma_req));

   // R8
   dma_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|dma_req) |-> valid_sum);

   // R7
   ovr_within_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_sum |-> valid_sum);
endmodule

// File: tb/adc_result_bank_tb_top.sv
module adc_result_bank_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fmt_twos = 1'b0;
   logic [3:0]  dbl_en = '0;
   logic [18:0] dma_en = '0;
   logic        done_i = 1'b0;
   logic [4:0]  done_slot = '0;
   logic [11:0] raw_i = '0;
   logic        rd_en = 1'b0;
   logic [4:0]  rd_slot = '0;
   logic        rd_sec = 1'b0;
   logic [17:0] rd_data;
   logic        valid_sum, ovr_sum;
   logic [18:0] dma_req;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_result_bank dut_i (
      .clk(clk), .rst_n(rst_n), .fmt_twos(fmt_twos), .dbl_en(dbl_en),
      .dma_en(dma_en), .done_i(done_i), .done_slot(done_slot), .raw_i(raw_i),
      .rd_en(rd_en), .rd_slot(rd_slot), .rd_sec(rd_sec), .rd_data(rd_data),
      .valid_sum(valid_sum), .ovr_sum(ovr_sum), .dma_req(dma_req)
   );

   // {slot[4:0], twos, raw[11:0], expected result[15:0]}
   localparam logic [33:0] VEC [8] = '{
      {5'd0,  1'b0, 12'h800, 16'h0800},
      {5'd1,  1'b1, 12'h800, 16'h0000},
      {5'd2,  1'b0, 12'hFFF, 16'h0FFF},
      {5'd9,  1'b1, 12'hFFF, 16'h07FF},
      {5'd10, 1'b1, 12'h000, 16'hF800},
      {5'd11, 1'b1, 12'h7FF, 16'hFFFF},
      {5'd18, 1'b1, 12'h123, 16'hF923},
      {5'd17, 1'b0, 12'h000, 16'h0000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] s, input logic tw, input logic [11:0] r);
      @(negedge clk);
      done_i = 1'b1; done_slot = s; fmt_twos = tw; raw_i = r;
      @(negedge clk);
      done_i = 1'b0;
   endtask

   task automatic peek(input logic [4:0] s, input logic sec, output logic [17:0] d);
      rd_en = 1'b0; rd_slot = s; rd_sec = sec;
      #1;
      d = rd_data;
   endtask

   task automatic rdclr(input logic [4:0] s, input logic sec, output logic [17:0] d);
      @(negedge clk);
      rd_en = 1'b1; rd_slot = s; rd_sec = sec;
      #1;
      d = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [17:0] d;
      repeat (3) @(negedge clk);
      // R1 reset state
      peek(5'd0, 1'b0, d);
      chk("R1 reset word", 32'(d), 32'h0);
      chk("R1 reset sums", {30'b0, valid_sum, ovr_sum}, 32'h0);
      chk("R1 reset dma", 32'(dma_req), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3 format table, read back and cleared
      for (int k = 0; k < 8; k++) begin
         wr(VEC[k][33:29], VEC[k][28], VEC[k][27:16]);
         rdclr(VEC[k][33:29], 1'b0, d);
         chk(VEC[k][28] ? "R3 twos format" : "R2 straight format",
             32'(d), {14'b0, 2'b10, VEC[k][15:0]});
      end
      @(negedge clk);
      chk("R7 sums clear after reads", {30'b0, valid_sum, ovr_sum}, 32'h0);

      // R5 overrun, R7 summaries
      wr(5'd5, 1'b0, 12'h111);
      chk("R7 valid_sum set", 32'(valid_sum), 32'h1);
      chk("R7 ovr_sum idle", 32'(ovr_sum), 32'h0);
      wr(5'd5, 1'b0, 12'h222);
      wr(5'd5, 1'b0, 12'h333);
      peek(5'd5, 1'b0, d);
      chk("R5 overrun sticky", 32'(d), {14'b0, 2'b11, 16'h0333});
      chk("R7 ovr_sum set", 32'(ovr_sum), 32'h1);
      // R6 read clears flags, keeps result
      rdclr(5'd5, 1'b0, d);
      peek(5'd5, 1'b0, d);
      chk("R6 read clears flags", 32'(d), {14'b0, 2'b00, 16'h0333});
      chk("R7 sums after clear", {30'b0, valid_sum, ovr_sum}, 32'h0);

      // R6 same-cycle read and write
      wr(5'd3, 1'b0, 12'h0AA);
      @(negedge clk);
      done_i = 1'b1; done_slot = 5'd3; raw_i = 12'h0BB; fmt_twos = 1'b0;
      rd_en = 1'b1; rd_slot = 5'd3; rd_sec = 1'b0;
      @(negedge clk);
      done_i = 1'b0; rd_en = 1'b0;
      peek(5'd3, 1'b0, d);
      chk("R6 read+write same cycle", 32'(d), {14'b0, 2'b10, 16'h00BB});
      rdclr(5'd3, 1'b0, d);

      // R4 out-of-range slot ignored
      dma_en = '1;
      wr(5'd19, 1'b0, 12'h555);
      chk("R4 slot 19 no valid", 32'(valid_sum), 32'h0);
      chk("R4 slot 19 no dma", 32'(dma_req), 32'h0);
      wr(5'd31, 1'b0, 12'h555);
      chk("R4 slot 31 no valid", 32'(valid_sum), 32'h0);
      peek(5'd19, 1'b0, d);
      chk("R9 out-of-range read zero", 32'(d), 32'h0);

      // R8 dma pulse
      dma_en = 19'h0;
      dma_en[7] = 1'b1;
      wr(5'd7, 1'b0, 12'h077);
      chk("R8 dma pulse slot 7", 32'(dma_req), 32'h80);
      @(negedge clk);
      chk("R8 dma pulse one cycle", 32'(dma_req), 32'h0);
      wr(5'd8, 1'b0, 12'h088);
      chk("R8 dma masked slot 8", 32'(dma_req), 32'h0);
      rdclr(5'd7, 1'b0, d);
      rdclr(5'd8, 1'b0, d);
      dma_en = '0;

      // R9 double buffer on slot 2
      dbl_en = 4'b0100;
      wr(5'd2, 1'b0, 12'h001);
      wr(5'd2, 1'b0, 12'h002);
      peek(5'd2, 1'b0, d);
      chk("R9 first write to primary", 32'(d), {14'b0, 2'b10, 16'h0001});
      peek(5'd2, 1'b1, d);
      chk("R9 second write to secondary", 32'(d), {14'b0, 2'b10, 16'h0002});
      wr(5'd2, 1'b0, 12'h003);
      peek(5'd2, 1'b0, d);
      chk("R9 third write wraps to primary", 32'(d), {14'b0, 2'b11, 16'h0003});
      rdclr(5'd2, 1'b0, d);
      chk("R7 secondary keeps valid_sum", 32'(valid_sum), 32'h1);
      rdclr(5'd2, 1'b1, d);
      chk("R9 secondary read clears", {30'b0, valid_sum, ovr_sum}, 32'h0);
      // pointer now on secondary; disabling returns writes to primary
      dbl_en = 4'b0000;
      wr(5'd2, 1'b0, 12'h004);
      wr(5'd2, 1'b0, 12'h005);
      peek(5'd2, 1'b1, d);
      chk("R9 disabled keeps secondary", 32'(d), {14'b0, 2'b00, 16'h0002});
      peek(5'd2, 1'b0, d);
      chk("R9 disabled writes primary", 32'(d), {14'b0, 2'b11, 16'h0005});
      rdclr(5'd2, 1'b0, d);
      dbl_en = 4'b0100;
      wr(5'd2, 1'b0, 12'h006);
      peek(5'd2, 1'b0, d);
      chk("R9 re-enable starts primary", 32'(d), {14'b0, 2'b10, 16'h0006});
      peek(5'd12, 1'b1, d);
      chk("R9 no secondary on slot 12", 32'(d), 32'h0);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule